// File: doc/BRIEF.md
# UART Line Status Tracker

This block keeps the line status byte of a 16550-class serial port. It follows the receive and transmit queues through their push and pop events, without holding the data itself. It keeps a side record of the error tag of every received character, so the parity, framing and break flags show only when the faulty character reaches the head of the receive queue. A sticky summary bit tells software that a faulty character sits somewhere in the queue. The block also works out the holding-register-empty and transmitter-empty flags, and raises the receive-line-status interrupt request.

A strobe read returns the status byte and applies the clear-on-read side effects at the same clock edge. The status byte has no write path. A mode input picks between single-character operation and queued operation. In single-character operation each direction holds one character and the summary bit reads 0.

Top module: `uart_lsr`

## Requirements
- R1: After synchronous reset, with the shift register idle, `lsr_rdata` is 0x60 (bits 5 and 6 set, all others clear) and `rls_irq` is 0.
- R2: Bit 0 is 1 exactly while the receive queue holds at least one character; a pop of an empty queue has no effect.
- R3: A push while the receive queue is full sets bit 1 and drops the character, so the queue depth does not change.
- R4: When a character becomes the head of the receive queue, its tag sets the head flags: tag bit 0 (parity) sets status bit 2, tag bit 1 (framing) sets bit 3, tag bit 2 (break) sets bit 4. A character is reported once while it stays at the head.
- R5: A read clears bits 1 to 4 at the read edge. A flag that is set at the same edge stays set.
- R6: In queued mode, bit 7 sets once any tagged character is in the queue (a tag is faulty if any of its three bits is 1). A read clears it only when no tagged character remains. Popping the last tagged character without a read leaves it set.
- R7: In single-character mode, bit 7 reads 0.
- R8: Bit 5 is 1 while the transmit queue is empty. It drops after a CPU write and returns once the last queued byte has moved to the shift register.
- R9: Bit 6 is 1 only while the transmit queue is empty and `tx_shift_busy` is 0.
- R10: `rls_irq` is 1 exactly when `rls_int_en` is 1 and any of bits 1 to 4 is set.
- R11: The queue capacity is 1 in single-character mode and RX_DEPTH / TX_DEPTH in queued mode. A transmit write into a full queue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | 1 = queued mode, 0 = single-character mode |
| rx_push | input | 1 | Receiver delivers a character |
| rx_push_err | input | 3 | Error tag of the pushed character: [0] parity, [1] framing, [2] break |
| rx_pop | input | 1 | CPU takes the head receive character |
| tx_push | input | 1 | CPU writes a byte for transmission |
| tx_pop | input | 1 | Byte moves from the holding queue to the shift register |
| tx_shift_busy | input | 1 | Shift register holds a character |
| lsr_rd | input | 1 | Status read strobe |
| rls_int_en | input | 1 | Receive-line-status interrupt enable |
| lsr_rdata | output | 8 | Status byte |
| rls_irq | output | 1 | Receive-line-status interrupt request |

## Verification
The assertions assume that `fifo_mode` changes only while reset is held. They also assume that the pop events come from the same queues the block tracks, so the depth counters never go out of step with the real queues. The stimulus sets the mode before each reset is released and keeps it fixed until the next reset. Some pops and transmit writes deliberately go to an empty or full queue, to show that the block ignores them. Every status check waits two clock edges after its stimulus cycle, which covers the one-cycle head-report and summary-bit latency.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;

    typedef struct packed {
        logic brk;
        logic framing;
        logic parity;
    } rx_err_t;

    localparam int LsrDr   = 0;
    localparam int LsrOe   = 1;
    localparam int LsrPe   = 2;
    localparam int LsrFe   = 3;
    localparam int LsrBi   = 4;
    localparam int LsrThre = 5;
    localparam int LsrTemt = 6;
    localparam int LsrFerr = 7;

    localparam int NumSticky = 4;

    function automatic logic tag_is_bad(rx_err_t t);
        return t.brk | t.framing | t.parity;
    endfunction

endpackage

// File: rtl/lsr_rx_tags.sv
module lsr_rx_tags
    import uart_lsr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    fifo_mode,
    input  logic    push,
    input  rx_err_t push_tag,
    input  logic    pop,
    output logic    has_data,
    output logic    overrun_evt,
    output logic    head_evt,
    output rx_err_t head_tag,
    output logic    err_present
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rx_err_t        tags [DEPTH];
    logic [PW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  cnt, err_cnt, cap;
    logic           full, push_ok, pop_ok, head_seen;

    function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign cap     = fifo_mode ? CW'(DEPTH) : CW'(1);
    assign full    = (cnt >= cap);
    assign push_ok = push && !full;
    assign pop_ok  = pop && (cnt != '0);

    always_ff @(posedge clk) begin
        if (push_ok) tags[wr_ptr] <= push_tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            cnt       <= '0;
            err_cnt   <= '0;
            head_seen <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
            cnt     <= cnt + CW'(push_ok) - CW'(pop_ok);
            err_cnt <= err_cnt + CW'(push_ok && tag_is_bad(push_tag))
                               - CW'(pop_ok && tag_is_bad(tags[rd_ptr]));
            if (pop_ok)           head_seen <= 1'b0;
            else if (cnt != '0)   head_seen <= 1'b1;
        end
    end

    assign has_data    = (cnt != '0);
    assign overrun_evt = push && full;
    assign head_evt    = has_data && !head_seen;
    assign head_tag    = tags[rd_ptr];
    assign err_present = (err_cnt != '0);

    // R11: occupancy never exceeds the mode's capacity
    p_cnt_cap_r11: assert property (@(posedge clk) disable iff (rst)
        cnt <= cap);

    // R6: tagged characters are a subset of stored characters
    p_errcnt_r6: assert property (@(posedge clk) disable iff (rst)
        err_cnt <= cnt);

endmodule

// File: rtl/lsr_tx_level.sv
module lsr_tx_level #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fifo_mode,
    input  logic push,
    input  logic pop,
    output logic empty
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt, cap;
    logic          push_ok, pop_ok;

    assign cap     = fifo_mode ? CW'(DEPTH) : CW'(1);
    assign push_ok = push && (cnt < cap);
    assign pop_ok  = pop && (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
    end

    assign empty = (cnt == '0);

    // R8: a write without a transfer leaves the queue non-empty
    p_thre_write_r8: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> !empty);

endmodule

// File: rtl/lsr_flag_bank.sv
module lsr_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr)    flags[i] <= 1'b0;
        end

        // R5: a read with no concurrent set clears the flag
        p_clear_r5: assert property (@(posedge clk) disable iff (rst)
            (clr && !set[i]) |=> !flags[i]);
    end

endmodule

// File: rtl/uart_lsr.sv
module uart_lsr
    import uart_lsr_pkg::*;
#(
    parameter int RX_DEPTH = 16,
    parameter int TX_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fifo_mode,
    input  logic       rx_push,
    input  logic [2:0] rx_push_err,
    input  logic       rx_pop,
    input  logic       tx_push,
    input  logic       tx_pop,
    input  logic       tx_shift_busy,
    input  logic       lsr_rd,
    input  logic       rls_int_en,
    output logic [7:0] lsr_rdata,
    output logic       rls_irq
);
    logic                 has_data, overrun_evt, head_evt, err_present, tx_empty;
    rx_err_t              head_tag;
    logic [NumSticky-1:0] sticky_set, sticky;
    logic                 ferr_q;

    lsr_rx_tags #(.DEPTH(RX_DEPTH)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .fifo_mode   (fifo_mode),
        .push        (rx_push),
        .push_tag    (rx_err_t'(rx_push_err)),
        .pop         (rx_pop),
        .has_data    (has_data),
        .overrun_evt (overrun_evt),
        .head_evt    (head_evt),
        .head_tag    (head_tag),
        .err_present (err_present)
    );

    lsr_tx_level #(.DEPTH(TX_DEPTH)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .fifo_mode (fifo_mode),
        .push      (tx_push),
        .pop       (tx_pop),
        .empty     (tx_empty)
    );

    assign sticky_set = {head_evt && head_tag.brk,
                         head_evt && head_tag.framing,
                         head_evt && head_tag.parity,
                         overrun_evt};

    lsr_flag_bank #(.N(NumSticky)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .set   (sticky_set),
        .clr   (lsr_rd),
        .flags (sticky)
    );

    always_ff @(posedge clk) begin
        if (rst)              ferr_q <= 1'b0;
        else if (!fifo_mode)  ferr_q <= 1'b0;
        else if (err_present) ferr_q <= 1'b1;
        else if (lsr_rd)      ferr_q <= 1'b0;
    end

    always_comb begin
        lsr_rdata                     = '0;
        lsr_rdata[LsrDr]              = has_data;
        lsr_rdata[LsrBi:LsrOe]        = sticky;
        lsr_rdata[LsrThre]            = tx_empty;
        lsr_rdata[LsrTemt]            = tx_empty && !tx_shift_busy;
        lsr_rdata[LsrFerr]            = ferr_q;
    end

    assign rls_irq = rls_int_en && (|sticky);

    // R3: an overrun event is visible in bit 1 on the next cycle
    p_ovr_r3: assert property (@(posedge clk) disable iff (rst)
        overrun_evt |=> lsr_rdata[LsrOe]);

    // R7: summary bit stays low in single-character mode
    p_b7_off_r7: assert property (@(posedge clk) disable iff (rst)
        !fifo_mode |-> !lsr_rdata[LsrFerr]);

endmodule

// File: tb/uart_lsr_tb.sv
module uart_lsr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 14;

    typedef struct packed {
        logic       push;
        logic [2:0] tag;
        logic       pop;
        logic       txw;
        logic       txl;
        logic       busy;
        logic       rd;
        logic [7:0] exp;
    } vec_t;

    // queued mode walk, rls_int_en = 1
    localparam vec_t TBL [NV] = '{
        '{1'b1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h61}, // R2 push clean
        '{1'b1, 3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hE1}, // R6 tagged behind head
        '{1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hE9}, // R4 framing at head
        '{1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hE1}, // R5 read clears FE
        '{1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hE0}, // R6 bit7 sticky
        '{1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h60}, // R6 read clears bit7
        '{1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // R8 tx write
        '{1'b0, 3'b000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h20}, // R9 shifting
        '{1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h60}, // R9 idle
        '{1'b1, 3'b101, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hF5}, // R4 parity+break
        '{1'b1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hE1}, // R5 read, R6 stays
        '{1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hE1}, // R6 clean head
        '{1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h61}, // R6 cleared
        '{1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h60}  // R2 empty
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_mode = 1'b1;
    logic       rx_push = 1'b0;
    logic [2:0] rx_push_err = '0;
    logic       rx_pop = 1'b0;
    logic       tx_push = 1'b0;
    logic       tx_pop = 1'b0;
    logic       tx_shift_busy = 1'b0;
    logic       lsr_rd = 1'b0;
    logic       rls_int_en = 1'b1;
    logic [7:0] lsr_rdata;
    logic       rls_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_lsr #(.RX_DEPTH(4), .TX_DEPTH(4)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .fifo_mode     (fifo_mode),
        .rx_push       (rx_push),
        .rx_push_err   (rx_push_err),
        .rx_pop        (rx_pop),
        .tx_push       (tx_push),
        .tx_pop        (tx_pop),
        .tx_shift_busy (tx_shift_busy),
        .lsr_rd        (lsr_rd),
        .rls_int_en    (rls_int_en),
        .lsr_rdata     (lsr_rdata),
        .rls_irq       (rls_irq)
    );

    task automatic check(input string req, input logic [7:0] exp);
        logic exp_irq;
        exp_irq = rls_int_en && (|exp[4:1]);
        checks++;
        if (lsr_rdata !== exp || rls_irq !== exp_irq) begin
            failures++;
            $display("FAIL %s: lsr=%02h irq=%b expected lsr=%02h irq=%b",
                     req, lsr_rdata, rls_irq, exp, exp_irq);
        end
    endtask

    task automatic idle_inputs();
        rx_push = 0; rx_push_err = '0; rx_pop = 0;
        tx_push = 0; tx_pop = 0; lsr_rd = 0;
    endtask

    // one stimulus cycle, one idle cycle, then sample
    task automatic step(input logic push, input logic [2:0] tag, input logic pop,
                        input logic txw, input logic txl, input logic busy,
                        input logic rd, input logic [7:0] exp, input string req);
        @(negedge clk);
        rx_push = push; rx_push_err = tag; rx_pop = pop;
        tx_push = txw; tx_pop = txl; tx_shift_busy = busy; lsr_rd = rd;
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
        check(req, exp);
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        idle_inputs();
        rst = 1; fifo_mode = mode; tx_shift_busy = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);
        check("R1 reset value", 8'h60);

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].push, TBL[i].tag, TBL[i].pop, TBL[i].txw, TBL[i].txl,
                 TBL[i].busy, TBL[i].rd, TBL[i].exp, $sformatf("R4/R5/R6/R8 vector %0d", i));
        end

        // R3 overrun at capacity 4, R10 interrupt gating
        for (int i = 0; i < 4; i++) step(1, 3'b000, 0, 0, 0, 0, 0, 8'h61, "R2 fill");
        step(1, 3'b000, 0, 0, 0, 0, 0, 8'h63, "R3 overrun sets bit1");
        rls_int_en = 0;
        #1 check("R10 irq masked", 8'h63);
        rls_int_en = 1;
        #1 check("R10 irq enabled", 8'h63);
        step(0, 3'b000, 0, 0, 0, 0, 1, 8'h61, "R5 read clears overrun");
        for (int i = 0; i < 3; i++) step(0, 3'b000, 1, 0, 0, 0, 0, 8'h61, "R3 drain");
        step(0, 3'b000, 1, 0, 0, 0, 0, 8'h60, "R3 dropped char not stored");
        step(0, 3'b000, 1, 0, 0, 0, 0, 8'h60, "R2 pop of empty ignored");

        // R5 read at the same edge as a head report: set wins
        @(negedge clk);
        rx_push = 1; rx_push_err = 3'b010;
        @(negedge clk);
        idle_inputs(); lsr_rd = 1;
        @(negedge clk);
        idle_inputs();
        check("R5 set wins over read", 8'hE9);
        step(0, 3'b000, 0, 0, 0, 0, 1, 8'hE1, "R5 later read clears");
        step(0, 3'b000, 1, 0, 0, 0, 0, 8'hE0, "R6 bit7 held after pop");
        step(0, 3'b000, 0, 0, 0, 0, 1, 8'h60, "R6 bit7 read clear");

        // R8/R11 transmit capacity 4
        for (int i = 0; i < 5; i++) step(0, 3'b000, 0, 1, 0, 0, 0, 8'h00, "R8 tx fill");
        for (int i = 0; i < 3; i++) step(0, 3'b000, 0, 0, 1, 0, 0, 8'h00, "R8 tx draining");
        step(0, 3'b000, 0, 0, 1, 0, 0, 8'h60, "R11 fifth tx write dropped");

        // single-character mode
        do_reset(1'b0);
        check("R1 reset value 450", 8'h60);
        step(1, 3'b010, 0, 0, 0, 0, 0, 8'h69, "R7 bit7 low with framing");
        step(1, 3'b000, 0, 0, 0, 0, 0, 8'h6B, "R11 capacity one overrun");
        step(0, 3'b000, 0, 0, 0, 0, 1, 8'h61, "R5 read in 450 mode");
        step(0, 3'b000, 1, 0, 0, 0, 0, 8'h60, "R11 single char drained");
        step(0, 3'b000, 0, 1, 0, 0, 0, 8'h00, "R8 450 tx write");
        step(0, 3'b000, 0, 1, 0, 0, 0, 8'h00, "R11 second tx write");
        step(0, 3'b000, 0, 0, 1, 1, 0, 8'h20, "R11 one transfer empties, R9 busy");
        step(0, 3'b000, 0, 0, 0, 0, 0, 8'h60, "R9 shift idle");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule